// File: doc/BRIEF.md
# Per-Port Statistics Counter Bank with Flush and Freeze Control

This block holds a set of event counters for five switch ports. Each port has `NUM_EVENTS` counters, and each counter has its own increment strobe. Whatever decodes traffic events drives these strobes. One control byte sets the block's behaviour:

- A five-bit port mask, with bit 0 for the first port up to bit 4 for the fifth.
- A freeze bit, which halts counting on the masked ports.
- A flush request bit, which clears every counter of the masked ports.

The flush is a sweep over the counter storage that clears one entry per clock. The entries are numbered `port * NUM_EVENTS + event`. The sweep goes through them in ascending order and visits every entry. It clears an entry only if that entry's port was in the mask when the flush started. For the whole sweep the request bit reads back as 1, and it drops to 0 by itself when the sweep ends. Software or a management agent reads the counters combinationally by port and event index.

Top module: `stat_mib_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x00 and every counter reads 0.
- R2: Each clock edge on which an entry's increment strobe is high adds exactly one to that entry, unless freeze, flush clearing or flush discarding applies. The entry is selected for reading by `rd_port` (0 = first port) and `rd_event`.
- R3: Counters are `CNT_W` bits wide (32 by default) and wrap from all-ones to zero.
- R4: Control bit 5 is reserved. It always reads 0, and writing it has no effect.
- R5: While control bit 6 (freeze) is 1, strobes to ports whose mask bit is 1 are ignored. Ports whose mask bit is 0 keep counting.
- R6: Writing control bit 7 = 1 while no flush is running starts a flush. Bit 7 reads 1 for exactly `5 * NUM_EVENTS` cycles, and then reads 0. Afterwards every counter of a masked port is 0, and counters of unmasked ports are unchanged.
- R7: The flush clears entries in ascending index order, one per cycle. During the flush, a strobe to a masked entry that has not yet been cleared is discarded, including a strobe on the cycle the entry itself is cleared. A strobe to a masked entry that has already been cleared counts normally.
- R8: The mask in force for a flush is captured when the flush starts. Mask writes during the flush change the readback and the freeze selection, but they do not change which entries the flush clears.
- R9: Writing bit 7 = 1 while a flush is running neither restarts nor extends that flush.
- R10: Control bits 6 and 4..0 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_inc | input | 5*NUM_EVENTS | Increment strobes, bit `port*NUM_EVENTS+event` |
| ctrl_wr | input | 1 | Control byte write enable |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte readback: bit 7 flush busy, bit 6 freeze, bit 5 zero, bits 4..0 mask |
| rd_port | input | 3 | Port index of the counter to read |
| rd_event | input | clog2(NUM_EVENTS) | Event index of the counter to read |
| rd_count | output | CNT_W | Value of the selected counter |

## Verification
A control write or a strobe shows up on the same clock edge that samples it. The new control byte and counter value can therefore be read just after that edge. A flush written on edge T clears entry k on edge T+1+k, and bit 7 falls on edge T+5*NUM_EVENTS. The reference model in the bench applies every input at the edge that samples it. All inputs are driven 2 ns after a rising edge. Every comparison, modelled or directed, is made at the falling edge or shortly after it, so each result is read in the half-cycle after the edge that produced it.

// File: rtl/stat_pkg.sv
// Shared constants and types for the statistics counter bank.
// Assumes the control byte layout is fixed: the mask occupies the low bits.
package stat_pkg;
    localparam int NUM_PORTS  = 5;
    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int CTRL_W     = 8;
    localparam int BIT_FLUSH  = 7;
    localparam int BIT_FREEZE = 6;
    localparam int BIT_RSVD   = 5;

    typedef struct packed {
        logic                 freeze;
        logic [NUM_PORTS-1:0] mask;
    } ctrl_t;
endpackage

// File: rtl/stat_ctrl_reg.sv
// Control byte register: holds freeze and port mask, forms the readback byte
// and issues a one-cycle flush start when a flush request arrives while idle.
// Assumes the flush sequencer reports its busy state back combinationally.
module stat_ctrl_reg
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              flush_busy,
    output ctrl_t             ctrl,
    output logic              flush_start,
    output logic [CTRL_W-1:0] rdata
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[BIT_RSVD];

    // Capture freeze and mask on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.freeze <= wdata[BIT_FREEZE];
            ctrl.mask   <= wdata[NUM_PORTS-1:0];
        end
    end

    // A request while busy is dropped; only an idle request starts a sweep.
    assign flush_start = wr && wdata[BIT_FLUSH] && !flush_busy;

    // Assemble the readback byte; the reserved bit stays zero.
    always_comb begin
        rdata                  = '0;
        rdata[BIT_FLUSH]       = flush_busy;
        rdata[BIT_FREEZE]      = ctrl.freeze;
        rdata[NUM_PORTS-1:0]   = ctrl.mask;
    end
endmodule

// File: rtl/stat_flush_seq.sv
// Flush sequencer: walks the counter entries one per cycle in ascending order,
// using a mask captured at start. Emits per-entry clear and discard vectors.
// Assumes entry index = port * NUM_EVENTS + event.
module stat_flush_seq
    import stat_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    parameter int ENTRIES    = NUM_PORTS * NUM_EVENTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_PORTS-1:0] start_mask,
    output logic                 busy,
    output logic [ENTRIES-1:0]   clr,
    output logic [ENTRIES-1:0]   blk
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]     idx;
    logic [NUM_PORTS-1:0] fmask;

    // Sweep state: start latches the mask, then the index advances to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            fmask <= '0;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            fmask <= start_mask;
        end
    end

    // Per-entry clear (current entry) and discard (entries still ahead).
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign clr[e] = busy && (idx == IDX_W'(e)) && fmask[e / NUM_EVENTS];
        assign blk[e] = busy && (IDX_W'(e) > idx) && fmask[e / NUM_EVENTS];
    end

    a_r6_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (idx != LAST) |=> busy && (idx == $past(idx) + 1'b1));
    a_r6_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (idx == LAST) |=> !busy);
    a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(fmask)));
endmodule

// File: rtl/stat_counter_bank.sv
// Counter storage: one wrapping counter per entry with clear, discard and
// freeze qualifiers, plus a combinational read mux by port and event.
// Assumes clear has priority over any increment in the same cycle.
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    parameter int CNT_W      = 32,
    parameter int ENTRIES    = NUM_PORTS * NUM_EVENTS,
    parameter int EV_W       = $clog2(NUM_EVENTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ENTRIES-1:0] inc,
    input  logic [ENTRIES-1:0] clr,
    input  logic [ENTRIES-1:0] blk,
    input  logic [ENTRIES-1:0] frz,
    input  logic [PORT_W-1:0] rd_port,
    input  logic [EV_W-1:0]   rd_event,
    output logic [CNT_W-1:0]  rd_count
);
    logic [ENTRIES-1:0][CNT_W-1:0] cnt;

    // Update every entry: clear first, otherwise count if not suppressed.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n || clr[e]) begin
                cnt[e] <= '0;
            end else if (inc[e] && !blk[e] && !frz[e]) begin
                cnt[e] <= cnt[e] + 1'b1;
            end
        end
    end

    // Select the addressed entry; out-of-range addresses read zero.
    always_comb begin
        int sel;
        sel      = int'(rd_port) * NUM_EVENTS + int'(rd_event);
        rd_count = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (sel == e) rd_count = cnt[e];
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        a_r7_cleared_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clr[e] |=> cnt[e] == '0);
        a_r7_discard_hold: assert property (@(posedge clk) disable iff (!rst_n)
            blk[e] && !clr[e] |=> cnt[e] == $past(cnt[e]));
        a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
            frz[e] && !clr[e] |=> cnt[e] == $past(cnt[e]));
        a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            inc[e] && !clr[e] && !blk[e] && !frz[e] |=> cnt[e] == $past(cnt[e]) + 1'b1);
    end
endmodule

// File: rtl/stat_mib_ctrl.sv
// Top of the per-port statistics counter bank. Connects the control byte,
// the flush sequencer and the counter storage, and expands the freeze
// selection from ports to entries.
// Assumes NUM_EVENTS >= 2 so the event index has at least one bit.
module stat_mib_ctrl
    import stat_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    parameter int CNT_W      = 32,
    localparam int ENTRIES   = NUM_PORTS * NUM_EVENTS,
    localparam int EV_W      = $clog2(NUM_EVENTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] evt_inc,
    input  logic               ctrl_wr,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    output logic [CTRL_W-1:0]  ctrl_rdata,
    input  logic [PORT_W-1:0]  rd_port,
    input  logic [EV_W-1:0]    rd_event,
    output logic [CNT_W-1:0]   rd_count
);
    ctrl_t              ctrl;
    logic               flush_start;
    logic               flush_busy;
    logic [ENTRIES-1:0] clr;
    logic [ENTRIES-1:0] blk;
    logic [ENTRIES-1:0] frz;

    stat_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctrl_wr),
        .wdata       (ctrl_wdata),
        .flush_busy  (flush_busy),
        .ctrl        (ctrl),
        .flush_start (flush_start),
        .rdata       (ctrl_rdata)
    );

    stat_flush_seq #(
        .NUM_EVENTS (NUM_EVENTS),
        .ENTRIES    (ENTRIES)
    ) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (flush_start),
        .start_mask (ctrl_wdata[NUM_PORTS-1:0]),
        .busy       (flush_busy),
        .clr        (clr),
        .blk        (blk)
    );

    // Freeze applies per entry through the live port mask.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_frz
        assign frz[e] = ctrl.freeze && ctrl.mask[e / NUM_EVENTS];
    end

    stat_counter_bank #(
        .NUM_EVENTS (NUM_EVENTS),
        .CNT_W      (CNT_W),
        .ENTRIES    (ENTRIES),
        .EV_W       (EV_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (evt_inc),
        .clr      (clr),
        .blk      (blk),
        .frz      (frz),
        .rd_port  (rd_port),
        .rd_event (rd_event),
        .rd_count (rd_count)
    );
endmodule

// File: tb/stat_mib_ctrl_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module stat_mib_ctrl_bench;
    import stat_pkg::*;
    localparam int NE  = 4;
    localparam int CW  = 8;
    localparam int ENT = NUM_PORTS * NE;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic [ENT-1:0] inc   = '0;
    logic           wr    = 1'b0;
    logic [7:0]     wd    = '0;
    logic [7:0]     ctrl_rdata;
    logic [2:0]     rp    = '0;
    logic [1:0]     re    = '0;
    logic [CW-1:0]  rc;

    stat_mib_ctrl #(.NUM_EVENTS(NE), .CNT_W(CW)) u_stat_mib_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_inc(inc), .ctrl_wr(wr), .ctrl_wdata(wd),
        .ctrl_rdata(ctrl_rdata), .rd_port(rp), .rd_event(re), .rd_count(rc)
    );

    int    errors = 0;
    int    checks = 0;
    bit    chk_on = 1'b0;
    bit    hold   = 1'b0;
    int    dp = 0, de = 0, scan = 0;
    string cur = "R1";

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state
    int       m_cnt[ENT];
    bit       m_busy = 1'b0, m_frz = 1'b0;
    int       m_idx = 0;
    bit [4:0] m_mask = '0, m_fmask = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) m_cnt[e] = 0;
            m_busy = 0; m_idx = 0; m_frz = 0; m_mask = '0; m_fmask = '0;
        end else begin
            for (int e = 0; e < ENT; e++) begin
                int p;
                p = e / NE;
                if (m_busy && m_idx == e && m_fmask[p]) m_cnt[e] = 0;
                else if (inc[e] && !(m_busy && e > m_idx && m_fmask[p]) && !(m_frz && m_mask[p]))
                    m_cnt[e] = (m_cnt[e] + 1) % (1 << CW);
            end
            if (m_busy) begin
                if (m_idx == ENT - 1) begin m_busy = 0; m_idx = 0; end
                else m_idx++;
            end else if (wr && wd[7]) begin
                m_busy = 1; m_idx = 0; m_fmask = wd[4:0];
            end
            if (wr) begin m_frz = wd[6]; m_mask = wd[4:0]; end
        end
    end

    // Per-cycle comparison against the model, then advance the read address.
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R6", int'(ctrl_rdata[7]), int'(m_busy));
            chk("R10", int'(ctrl_rdata[6:0]), int'({m_frz, 1'b0, m_mask}));
            chk(cur, int'(rc), m_cnt[int'(rp) * NE + int'(re)]);
        end
        if (hold) begin
            rp = 3'(dp); re = 2'(de);
        end else begin
            scan = (scan + 1) % ENT;
            rp = 3'(scan / NE); re = 2'(scan % NE);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        wr = 1'b1; wd = d; step(); wr = 1'b0;
    endtask

    task automatic rd(int p, int e, int exp, string tag);
        dp = p; de = e; hold = 1'b1;
        @(negedge clk); #2;
        chk(tag, int'(rc), exp);
        hold = 1'b0;
        step();
    endtask

    initial begin
        int n;
        repeat (3) step();
        chk_on = 1'b1;
        rst_n  = 1'b1;
        // R1: reset state
        chk("R1", int'(ctrl_rdata), 0);
        rd(0, 0, 0, "R1");
        rd(4, 3, 0, "R1");
        // R2: basic counting
        cur = "R2";
        inc[9] = 1'b1; inc[4] = 1'b1; step(); inc[4] = 1'b0;
        step(); step(); inc = '0;
        rd(2, 1, 3, "R2");
        rd(1, 0, 1, "R2");
        // R10: readback of freeze and mask
        cur = "R10";
        wr_ctrl(8'h45);
        chk("R10", int'(ctrl_rdata), 8'h45);
        // R4: reserved bit ignored
        cur = "R4";
        wr_ctrl(8'h3F);
        chk("R4", int'(ctrl_rdata[5]), 0);
        chk("R4", int'(ctrl_rdata), 8'h1F);
        // R5: freeze only affects masked ports
        cur = "R5";
        wr_ctrl(8'h41);
        inc[0] = 1'b1; inc[4] = 1'b1;
        repeat (5) step();
        inc = '0;
        rd(0, 0, 0, "R5");
        rd(1, 0, 6, "R5");
        wr_ctrl(8'h01);
        inc[0] = 1'b1; step(); step(); inc = '0;
        rd(0, 0, 2, "R5");
        // R3: wrap at CNT_W bits
        cur = "R3";
        inc[1] = 1'b1;
        repeat (260) step();
        inc = '0;
        rd(0, 1, 4, "R3");
        // R6, R8, R9: flush of port 1, mask change and re-request mid-flush
        cur = "R8";
        wr_ctrl(8'h82);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            if (ctrl_rdata[7]) n++;
            if (k == 3) begin wr = 1'b1; wd = 8'h84; end
            else wr = 1'b0;
            step();
        end
        chk("R6", n, ENT);
        chk("R9", n, ENT);
        chk("R8", int'(ctrl_rdata), 8'h04);
        rd(1, 0, 0, "R6");
        rd(2, 1, 3, "R8");
        rd(0, 1, 4, "R6");
        // R7: strobes during a flush of ports 0 and 4
        cur = "R7";
        inc[0] = 1'b1; inc[19] = 1'b1;
        wr_ctrl(8'h91);
        repeat (20) step();
        inc = '0;
        chk("R6", int'(ctrl_rdata[7]), 0);
        rd(0, 0, 19, "R7");
        rd(4, 3, 0, "R7");
        repeat (4) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule